// File: doc/BRIEF.md
# Masked Outer-Bank Program ROM Mapper

This block translates a CPU access in the upper 32 KB of the address space into a physical program-ROM bank number. That space is split into four 8 KB windows. Each window takes an inner bank value from its own register, a fixed value or a constant. A mode field selects how many low bits of that value are kept. The bits the mode masks off come from a base built from two other registers.

Software programs the block in two ways. It can write directly to a small register file in the 0x4100–0x413F range. It can also use command and data writes in the style of a common bank-switching controller in the 0x8000–0xFFFF range, and a lock bit can shut that path off. A command bit exchanges the first and third windows. The register addresses of the four inner bank registers are reordered by a build-time variant.

A last stage applies a board-level limit mask and a set of outer bank bits to every result. The lookup itself is combinational from the CPU address and the register state.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write is taken into the register file only when address bits [15:6] equal 0x104 (0x4100–0x413F), and bits [5:0] select the register. Writes to other addresses outside 0x8000–0xFFFF, such as 0x4140, change nothing.
- R2: The mode is bits [2:0] of register 0x0B. Mode 7 gives an inner mask of 0xFF, and any other mode m gives 0x3F >> m.
- R3: The base is (register 0x00 bits [7:4]) << 8, ORed with register 0x0A with its inner-mask bits cleared. The raw bank of a window is base | (value & mask), 12 bits wide.
- R4: The window values are as follows. Window 0x8000 takes register 0x07 and window 0xA000 takes register 0x08. Window 0xC000 takes register 0x09 when register 0x0B bit 6 is 1, and 0xFE otherwise. Window 0xE000 takes 0xFF. The window is selected by cpu_addr_i[14:13].
- R5: When command register bit 6 is 1, windows 0x8000 and 0xC000 exchange their values. Windows 0xA000 and 0xE000 are never affected by this bit.
- R6: With address bit 15 set and bits [14:13] clear, a write with bit 0 = 0 loads the command register. A write with bit 0 = 1 is a data write. A data write loads register 0x07 when command bits [2:0] = 6, loads register 0x08 when they = 7, and changes no bank for other command values.
- R7: While register 0x0B bit 3 is 1, writes in 0x8000–0xFFFF change neither the command register nor any bank.
- R8: Offsets 0x07–0x0A are written to register 0x07 plus a slot taken from a permutation table. Variant 0 uses slots (0,1,2,3). Variant 1 uses (1,0,2,3). Variant 2 uses (0,1,3,2).
- R9: Board 0 outputs raw & 0x0FFF. Board 1 outputs (raw & 0x07FF) | OR. Bit 0x0800 of OR is set when register 0x2C bit 1 or bit 2 is 1. Bit 0x1000 of OR is set when register 0x2C bit 0 is 1.
- R10: All registers clear to 0 on reset. After reset, windows 0..3 read 0x000, 0x000, 0x03E and 0x03F.
- R11: prg_bank_o follows cpu_addr_i combinationally. A register write is visible from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 16 | CPU address for bank lookup |
| prg_bank_o | output | 13 | Physical 8 KB program bank number |

## Verification
A register write takes effect at the clock edge that samples it. The bank output is combinational, so the new bank is due in the same cycle the register changes. For a change of lookup address alone, the new bank is due at once with no clock edge. The bench drives a write for one cycle starting at a falling edge and updates its model at the next falling edge. It then steps the lookup address through all four windows, waiting a short delay after each step, and compares the output before any further edge. Two instances, one per board and permutation variant, receive the same stimulus, so that both the limit/OR stage and the address reordering are checked every time.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int REG_W  = 8;
  localparam int RAW_W  = 12;
  localparam int BANK_W = 13;
  localparam int WIN_N  = 4;

  function automatic logic [1:0] perm_slot(input int variant, input logic [1:0] idx);
    case (variant)
      1:       perm_slot = (idx == 2'd0) ? 2'd1 : (idx == 2'd1) ? 2'd0 : idx;
      2:       perm_slot = (idx == 2'd2) ? 2'd3 : (idx == 2'd3) ? 2'd2 : idx;
      default: perm_slot = idx;
    endcase
  endfunction
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int PERM = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [15:0]                  wr_addr_i,
  input  logic [REG_W-1:0]             wr_data_i,
  output logic [REG_W-1:0]             outer_o,
  output logic [WIN_N-1:0][REG_W-1:0]  inner_o,
  output logic [REG_W-1:0]             ctrl_o,
  output logic [REG_W-1:0]             ext_o,
  output logic [REG_W-1:0]             cmd_o,
  output logic                         lock_o
);
  logic       rf_hit, ctl_hit, ctl_cmd, ctl_dat;
  logic [5:0] rf_idx;
  logic [1:0] slot;

  assign rf_hit  = wr_en_i && (wr_addr_i[15:6] == 10'h104);
  assign rf_idx  = wr_addr_i[5:0];
  assign lock_o  = ctrl_o[3];
  assign ctl_hit = wr_en_i && wr_addr_i[15] && (wr_addr_i[14:13] == 2'b00) && !lock_o;
  assign ctl_cmd = ctl_hit && !wr_addr_i[0];
  assign ctl_dat = ctl_hit && wr_addr_i[0];
  assign slot    = perm_slot(PERM, 2'(rf_idx - 6'd7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outer_o <= '0;
      inner_o <= '0;
      ctrl_o  <= '0;
      ext_o   <= '0;
      cmd_o   <= '0;
    end else begin
      if (rf_hit) begin
        case (rf_idx)
          6'h00:                      outer_o       <= wr_data_i;
          6'h07, 6'h08, 6'h09, 6'h0A: inner_o[slot] <= wr_data_i;
          6'h0B:                      ctrl_o        <= wr_data_i;
          6'h2C:                      ext_o         <= wr_data_i;
          default: ;
        endcase
      end
      if (ctl_cmd) cmd_o <= wr_data_i;
      if (ctl_dat) begin
        case (cmd_o[2:0])
          3'd6:    inner_o[0] <= wr_data_i;
          3'd7:    inner_o[1] <= wr_data_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mapper_bank_calc.sv
module mapper_bank_calc
  import mapper_pkg::*;
(
  input  logic [REG_W-1:0]             outer_i,
  input  logic [WIN_N-1:0][REG_W-1:0]  inner_i,
  input  logic [REG_W-1:0]             ctrl_i,
  input  logic                         swap_i,
  input  logic [1:0]                   win_i,
  output logic [RAW_W-1:0]             raw_o
);
  logic [REG_W-1:0]                mask;
  logic [RAW_W-1:0]                base;
  logic [WIN_N-1:0][REG_W-1:0]     val;
  logic [WIN_N-1:0][RAW_W-1:0]     win_bank;

  assign mask = (ctrl_i[2:0] == 3'd7) ? 8'hFF : (8'h3F >> ctrl_i[2:0]);
  assign base = {outer_i[7:4], 8'h00} | {4'h0, inner_i[3] & ~mask};

  assign val[0] = inner_i[0];
  assign val[1] = inner_i[1];
  assign val[2] = ctrl_i[6] ? inner_i[2] : 8'hFE;
  assign val[3] = 8'hFF;

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    localparam int SRC = (w == 0) ? 2 : (w == 2) ? 0 : w;
    logic [REG_W-1:0] sel;
    assign sel         = swap_i ? val[SRC] : val[w];
    assign win_bank[w] = base | {4'h0, sel & mask};
  end

  assign raw_o = win_bank[win_i];
endmodule

// File: rtl/mapper_outer.sv
module mapper_outer
  import mapper_pkg::*;
#(
  parameter int BOARD = 0
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [REG_W-1:0]  ext_i,
  output logic [BANK_W-1:0] bank_o
);
  if (BOARD == 1) begin : g_alt
    logic [BANK_W-1:0] or_bits;
    assign or_bits = {ext_i[0], ext_i[1] | ext_i[2], 11'h000};
    assign bank_o  = {1'b0, raw_i & 12'h7FF} | or_bits;
  end else begin : g_std
    assign bank_o = {1'b0, raw_i & 12'hFFF};
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import mapper_pkg::*;
#(
  parameter int BOARD = 0,
  parameter int PERM  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [15:0]       cpu_addr_i,
  output logic [12:0]       prg_bank_o
);
  logic [REG_W-1:0]            outer_q, ctrl_q, ext_q, cmd_q;
  logic [WIN_N-1:0][REG_W-1:0] inner_q;
  logic                        lock;
  logic [RAW_W-1:0]            raw;

  mapper_regs #(.PERM(PERM)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .outer_o(outer_q), .inner_o(inner_q), .ctrl_o(ctrl_q),
    .ext_o(ext_q), .cmd_o(cmd_q), .lock_o(lock)
  );

  mapper_bank_calc u_calc (
    .outer_i(outer_q), .inner_i(inner_q), .ctrl_i(ctrl_q),
    .swap_i(cmd_q[6]), .win_i(cpu_addr_i[14:13]), .raw_o(raw)
  );

  mapper_outer #(.BOARD(BOARD)) u_outer (
    .raw_i(raw), .ext_i(ext_q), .bank_o(prg_bank_o)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int BOARD = 0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_addr_i,
  input logic [15:0] cpu_addr_i,
  input logic [12:0] prg_bank_o,
  input logic [7:0]  cmd_q,
  input logic [7:0]  ext_q,
  input logic        lock
);
  logic ctl_wr, cmd_wr;
  assign ctl_wr = wr_en_i && wr_addr_i[15] && (wr_addr_i[14:13] == 2'b00);
  assign cmd_wr = ctl_wr && !wr_addr_i[0] && !lock;

  // R7
  a_r7_lock_holds_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && lock) |=> $stable(cmd_q));

  // R11
  a_r11_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(cpu_addr_i) -> $stable(prg_bank_o)));

  // R5
  a_r5_fixed_windows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && cpu_addr_i[13]) |=> ($stable(cpu_addr_i) -> $stable(prg_bank_o)));

  // R9
  a_r9_outer_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BOARD == 1) ? (prg_bank_o[12] == ext_q[0] && prg_bank_o[11] == (ext_q[1] | ext_q[2]))
                 : (prg_bank_o[12] == 1'b0));

  // R10
  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r10_reset_clear: assert (cmd_q == 8'h00 && ext_q == 8'h00);
  end
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BOARD(BOARD)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .cpu_addr_i(cpu_addr_i), .prg_bank_o(prg_bank_o), .cmd_q(cmd_q),
  .ext_q(ext_q), .lock(lock)
);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [12:0] bank0, bank1;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_r00, m_r0b, m_r2c, m_cmd;
  logic [7:0] m_in0 [4];
  logic [7:0] m_in1 [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper #(.BOARD(0), .PERM(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .prg_bank_o(bank0));

  prg_bank_mapper #(.BOARD(1), .PERM(1)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cpu_addr_i(cpu_addr), .prg_bank_o(bank1));

  function automatic int slot_of(int variant, int idx);
    if (variant == 1) return (idx == 0) ? 1 : (idx == 1) ? 0 : idx;
    return idx;
  endfunction

  function automatic logic [12:0] expect_bank(bit alt, int win);
    logic [7:0]  mask, v [4], sel;
    logic [11:0] base, raw;
    logic [12:0] orb;
    for (int i = 0; i < 4; i++) v[i] = alt ? m_in1[i] : m_in0[i];
    mask = (m_r0b[2:0] == 3'd7) ? 8'hFF : (8'h3F >> m_r0b[2:0]);
    base = {m_r00[7:4], 8'h00} | {4'h0, v[3] & ~mask};
    case (win)
      0: sel = m_cmd[6] ? (m_r0b[6] ? v[2] : 8'hFE) : v[0];
      1: sel = v[1];
      2: sel = m_cmd[6] ? v[0] : (m_r0b[6] ? v[2] : 8'hFE);
      default: sel = 8'hFF;
    endcase
    raw = base | {4'h0, sel & mask};
    if (!alt) return {1'b0, raw & 12'hFFF};
    orb = {m_r2c[0], m_r2c[1] | m_r2c[2], 11'h0};
    return {1'b0, raw & 12'h7FF} | orb;
  endfunction

  task automatic model_reset();
    m_r00 = 0; m_r0b = 0; m_r2c = 0; m_cmd = 0;
    for (int i = 0; i < 4; i++) begin m_in0[i] = 0; m_in1[i] = 0; end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a[15:6] == 10'h104) begin
      case (a[5:0])
        6'h00: m_r00 = d;
        6'h07, 6'h08, 6'h09, 6'h0A: begin
          m_in0[slot_of(0, int'(a[5:0]) - 7)] = d;
          m_in1[slot_of(1, int'(a[5:0]) - 7)] = d;
        end
        6'h0B: m_r0b = d;
        6'h2C: m_r2c = d;
        default: ;
      endcase
    end else if (a[15] && a[14:13] == 2'b00 && !m_r0b[3]) begin
      if (!a[0]) m_cmd = d;
      else if (m_cmd[2:0] == 3'd6) begin m_in0[0] = d; m_in1[0] = d; end
      else if (m_cmd[2:0] == 3'd7) begin m_in0[1] = d; m_in1[1] = d; end
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all(string tag);
    for (int w = 0; w < 4; w++) begin
      cpu_addr = {1'b1, 2'(w), 13'($urandom)};
      #1;
      checks += 2;
      if (bank0 !== expect_bank(0, w)) begin
        errors++;
        $display("FAIL %s board0 win%0d: actual %h expected %h", tag, w, bank0, expect_bank(0, w));
      end
      if (bank1 !== expect_bank(1, w)) begin
        errors++;
        $display("FAIL %s board1 win%0d: actual %h expected %h", tag, w, bank1, expect_bank(1, w));
      end
    end
  endtask

  task automatic rand_write();
    logic [15:0] a;
    logic [7:0]  d = 8'($urandom);
    case ($urandom % 8)
      0: a = 16'h4100;
      1: a = 16'h4107 + 16'($urandom % 4);
      2: begin a = 16'h410B; if ($urandom % 4 != 0) d[3] = 1'b0; end
      3: a = 16'h412C;
      4: a = {3'b100, 12'($urandom), 1'b0};
      5: a = {3'b100, 12'($urandom), 1'b1};
      6: a = 16'($urandom);
      default: a = {10'h104, 6'($urandom)};
    endcase
    do_write(a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset values 0,0,3E,3F
    check_all("R10 reset");

    // R2 R3: mode 7, base from 0x00 and 0x0A
    do_write(16'h4100, 8'hA5);
    do_write(16'h410A, 8'h3C);
    do_write(16'h410B, 8'h07);
    check_all("R2 R3 mode7");
    do_write(16'h410B, 8'h43);
    check_all("R2 R3 R4 mode3 reg09");
    // R8: offset 0x07 lands in different slots per variant
    do_write(16'h4107, 8'h11);
    do_write(16'h4108, 8'h22);
    do_write(16'h4109, 8'h33);
    check_all("R8 permute");
    // R6 R5: command swap and data writes
    do_write(16'h8000, 8'h46);
    do_write(16'h8001, 8'h19);
    check_all("R6 R5 swap cmd6");
    do_write(16'h9FFE, 8'h07);
    do_write(16'h8001, 8'h2A);
    check_all("R6 cmd7 noswap");
    do_write(16'hA000, 8'h46);
    do_write(16'hC001, 8'h55);
    check_all("R6 other ranges");
    // R1: outside the register file
    do_write(16'h4140, 8'hFF);
    do_write(16'h40FF, 8'hFF);
    check_all("R1 ignored");
    // R7: lock
    do_write(16'h410B, 8'h4B);
    do_write(16'h8000, 8'h06);
    do_write(16'h8001, 8'h77);
    check_all("R7 locked");
    do_write(16'h410B, 8'h40);
    // R9: outer OR bits
    do_write(16'h412C, 8'h05);
    check_all("R9 or 0x1800");
    do_write(16'h412C, 8'h02);
    check_all("R9 or 0x0800");
    // R11: one cycle visibility exercised by every check
    for (int i = 0; i < 400; i++) begin
      rand_write();
      check_all("R11 R2 R3 R4 random");
    end
    // R10: reset after activity
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R10 rereset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule